// File: doc/BRIEF.md
# Audio clock ratio detector

The block sits in the system clock domain of an audio receiver. It takes a free-running master clock, an asynchronous left/right word clock and one parallel audio sample per word clock period. It measures how many master clock cycles fit in each word clock period and classifies the ratio as 256 or 384 without any configuration input. The ratio is declared locked only after a run of consistent measurements.

Once locked, it compares each word clock rising edge with the position expected from the locked ratio. Small deviations pass unnoticed. A large deviation triggers a resynchronisation, and the sample stream toward the downstream datapath is corrected by one sample. An early edge drops the sample taken at that edge. A late edge repeats the previously delivered sample. This keeps the downstream rate continuous and limits audible clicks.

Top module: `audio_ratio_detector`

## Requirements
- R1: Reset (synchronous, active low) clears `locked`, `sample_valid` and `resync`, sets `ratio` to 0 (unknown) and sets `sample_out` to 0.
- R2: After four consecutive measured periods that each lie within 256±4 master clocks, `locked` rises and `ratio` reads 1. The boundary values 252 and 260 count as matches. A period is the count of master clocks between two synchronised word clock rising edges, and the first edge after reset measures nothing.
- R3: After four consecutive measured periods within 384±4 (380 and 388 included), `locked` rises and `ratio` reads 2.
- R4: A measured period outside both windows (for example 300) never counts toward lock and restarts the run of consecutive matches.
- R5: While unlocked, `sample_valid` stays low and `ratio` reads 0. The edge at which lock is reached delivers no sample.
- R6: While locked, an edge whose measured period is within ±16 of the locked ratio gives exactly one single-cycle `sample_valid` pulse, with `sample_out` equal to `sample_in` as held at that edge, and no `resync`.
- R7: While locked, a measured period shorter than the locked ratio minus 16 gives one single-cycle `resync` pulse and no `sample_valid` (the sample is dropped), and `sample_out` is unchanged.
- R8: While locked, a measured period longer than the locked ratio plus 16 gives one single-cycle `resync` pulse and one `sample_valid` pulse, with `sample_out` keeping the previous sample (repeat).
- R9: Once locked, lock is kept. A different ratio is adopted only after four consecutive periods match the other window. Those periods are handled as slips until the fourth one, and the edge that adopts the new ratio delivers a normal sample with no `resync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master (system) clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wclk_in | input | 1 | Asynchronous left/right word clock |
| sample_in | input | DATA_W | Audio sample, held stable around the word clock rising edge |
| sample_valid | output | 1 | Single-cycle strobe for a delivered sample |
| sample_out | output | DATA_W | Delivered sample |
| resync | output | 1 | Single-cycle pulse on a severe phase slip |
| locked | output | 1 | Ratio has been established |
| ratio | output | 2 | 0 unknown, 1 for 256, 2 for 384 |

## Verification
The hardest state to reach is a ratio change while locked. The new ratio must be confirmed over four periods that also count as slips, and a single period at the old ratio in the middle of the run must restart the count. The stimulus table drives exactly that sequence: three periods at 384, one at 256, then four at 384. Every slip in it, and the final adoption, is checked against the expected repeat and valid counts.

// File: rtl/arc_pkg.sv
// Shared types for the audio clock ratio detector.
package arc_pkg;
    // Code reported on the ratio port.
    typedef enum logic [1:0] {
        RATIO_NONE = 2'd0,
        RATIO_LO   = 2'd1,
        RATIO_HI   = 2'd2
    } ratio_e;
endpackage

// File: rtl/arc_wclk_sync.sv
// Brings the asynchronous word clock into the master clock domain through two
// flops and flags its rising edge for one cycle. Assumes the word clock high
// and low phases each last at least two master clocks.
module arc_wclk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_async,
    output logic rise
);
    logic [2:0] sh_q;

    // Synchroniser pair plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], wclk_async};
    end

    assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/arc_period_meter.sv
// Counts master clocks between synchronised word clock rising edges. At a rise,
// 'period' holds the length of the period just ended, and 'period_ok' says a
// previous edge exists. The counter saturates and never wraps.
module arc_period_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    output logic [CNT_W-1:0] period,
    output logic             period_ok
);
    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;

    // Restart at each edge, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (rise)         cnt_q <= CNT_W'(1);
        else if (~&cnt_q)      cnt_q <= cnt_q + 1'b1;
    end

    // Remember that a first edge has opened a measurement.
    always_ff @(posedge clk) begin
        if (!rst_n)    seen_q <= 1'b0;
        else if (rise) seen_q <= 1'b1;
    end

    assign period    = cnt_q;
    assign period_ok = seen_q;
endmodule

// File: rtl/arc_ratio_lock.sv
// Classifies each measured period into one of two ratio windows and runs the
// lock rule: LOCK_N consecutive matches of one class lock it, or replace the
// locked class. 'switch_now' is high in the edge cycle that replaces a locked
// ratio. Assumes LOCK_N >= 2.
module arc_ratio_lock
    import arc_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int RATIO_A   = 256,
    parameter int RATIO_B   = 384,
    parameter int MATCH_TOL = 4,
    parameter int LOCK_N    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             period_ok,
    input  logic [CNT_W-1:0] period,
    output logic             locked,
    output ratio_e           ratio,
    output logic             switch_now
);
    localparam int RUN_W = $clog2(LOCK_N + 1);

    logic [1:0]       hit;
    ratio_e           cls;
    ratio_e           ratio_q, cand_q, cand_n;
    logic             locked_q, adopt;
    logic [RUN_W-1:0] run_q, run_n;

    // One window comparator per supported ratio.
    for (genvar g = 0; g < 2; g++) begin : g_win
        localparam int REF = (g == 0) ? RATIO_A : RATIO_B;
        assign hit[g] = (int'(period) >= REF - MATCH_TOL) &&
                        (int'(period) <= REF + MATCH_TOL);
    end

    // Map window hits to a class code.
    always_comb begin
        if (hit[0])      cls = RATIO_LO;
        else if (hit[1]) cls = RATIO_HI;
        else             cls = RATIO_NONE;
    end

    // Next candidate and run length, and whether this edge adopts a class.
    always_comb begin
        cand_n = cand_q;
        run_n  = run_q;
        adopt  = 1'b0;
        if (rise && period_ok) begin
            if (cls == RATIO_NONE || (locked_q && cls == ratio_q)) begin
                cand_n = RATIO_NONE;
                run_n  = '0;
            end else if (cls == cand_q) begin
                if (run_q == RUN_W'(LOCK_N - 1)) begin
                    adopt  = 1'b1;
                    cand_n = RATIO_NONE;
                    run_n  = '0;
                end else begin
                    run_n = run_q + 1'b1;
                end
            end else begin
                cand_n = cls;
                run_n  = RUN_W'(1);
            end
        end
    end

    // Candidate tracking state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= RATIO_NONE;
            run_q  <= '0;
        end else begin
            cand_q <= cand_n;
            run_q  <= run_n;
        end
    end

    // Lock flag and adopted ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            ratio_q  <= RATIO_NONE;
        end else if (adopt) begin
            locked_q <= 1'b1;
            ratio_q  <= cls;
        end
    end

    assign locked     = locked_q;
    assign ratio      = ratio_q;
    assign switch_now = adopt & locked_q;
endmodule

// File: rtl/arc_slip_handler.sv
// Judges each word clock edge against the locked ratio and drives the sample
// stream: deliver normally, drop on an early edge or repeat on a late edge,
// with a resync pulse for either slip. Acts only while locked.
module arc_slip_handler
    import arc_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int DATA_W   = 16,
    parameter int RATIO_A  = 256,
    parameter int RATIO_B  = 384,
    parameter int SLIP_TOL = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              locked,
    input  ratio_e            ratio,
    input  logic              switch_now,
    input  logic [CNT_W-1:0]  period,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sample_valid,
    output logic [DATA_W-1:0] sample_out,
    output logic              resync
);
    int   expect_len;
    logic early, late;

    // Expected period for the ratio in force and the two slip directions.
    always_comb begin
        expect_len = (ratio == RATIO_HI) ? RATIO_B : RATIO_A;
        early      = int'(period) < expect_len - SLIP_TOL;
        late       = int'(period) > expect_len + SLIP_TOL;
    end

    // Output stream: pulses default low, sample register updated only on delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_valid <= 1'b0;
            resync       <= 1'b0;
            sample_out   <= '0;
        end else begin
            sample_valid <= 1'b0;
            resync       <= 1'b0;
            if (rise && locked) begin
                if (switch_now) begin
                    sample_valid <= 1'b1;
                    sample_out   <= sample_in;
                end else if (early) begin
                    resync <= 1'b1;
                end else if (late) begin
                    resync       <= 1'b1;
                    sample_valid <= 1'b1;
                end else begin
                    sample_valid <= 1'b1;
                    sample_out   <= sample_in;
                end
            end
        end
    end
endmodule

// File: rtl/audio_ratio_detector.sv
// Top level: word clock synchroniser, period meter, ratio lock and slip
// handling. Assumes one sample per word clock period, presented on sample_in
// around the word clock rising edge.
module audio_ratio_detector
    import arc_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int RATIO_A   = 256,
    parameter int RATIO_B   = 384,
    parameter int MATCH_TOL = 4,
    parameter int SLIP_TOL  = 16,
    parameter int LOCK_N    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wclk_in,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sample_valid,
    output logic [DATA_W-1:0] sample_out,
    output logic              resync,
    output logic              locked,
    output logic [1:0]        ratio
);
    localparam int CNT_W = $clog2(2 * RATIO_B);

    logic             rise, period_ok, switch_now, lock_q;
    logic [CNT_W-1:0] period;
    ratio_e           ratio_q;

    arc_wclk_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .wclk_async (wclk_in),
        .rise       (rise)
    );

    arc_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .period    (period),
        .period_ok (period_ok)
    );

    arc_ratio_lock #(
        .CNT_W(CNT_W), .RATIO_A(RATIO_A), .RATIO_B(RATIO_B),
        .MATCH_TOL(MATCH_TOL), .LOCK_N(LOCK_N)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .period_ok  (period_ok),
        .period     (period),
        .locked     (lock_q),
        .ratio      (ratio_q),
        .switch_now (switch_now)
    );

    arc_slip_handler #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .RATIO_A(RATIO_A),
        .RATIO_B(RATIO_B), .SLIP_TOL(SLIP_TOL)
    ) u_slip (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise         (rise),
        .locked       (lock_q),
        .ratio        (ratio_q),
        .switch_now   (switch_now),
        .period       (period),
        .sample_in    (sample_in),
        .sample_valid (sample_valid),
        .sample_out   (sample_out),
        .resync       (resync)
    );

    assign locked = lock_q;
    assign ratio  = ratio_q;
endmodule

// File: rtl/arc_checker.sv
// Port-level properties of the audio clock ratio detector, bound to the top.
module arc_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid,
    input logic [DATA_W-1:0] sample_out,
    input logic              resync,
    input logic              locked,
    input logic [1:0]        ratio
);
    // R5: no sample leaves while unlocked
    p_valid_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> locked);

    // R5: unlocked reads as unknown ratio
    p_unknown_when_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> ratio == 2'd0);

    // R2, R3: a locked ratio is one of the two legal codes
    p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (ratio == 2'd1 || ratio == 2'd2));

    // R7: resync is a single-cycle pulse
    p_resync_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !resync);

    // R6: sample_valid is a single-cycle pulse
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R8 (and R7): a slip never loads a new sample
    p_slip_keeps_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> $stable(sample_out));

    // R9: lock is never lost except through reset
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
endmodule

bind audio_ratio_detector arc_checker #(.DATA_W(DATA_W)) u_arc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_out   (sample_out),
    .resync       (resync),
    .locked       (locked),
    .ratio        (ratio)
);

// File: tb/audio_ratio_detector_bench.sv
module audio_ratio_detector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wclk = 1'b0;
    logic [15:0] sin = '0;
    logic        valid, resync, locked;
    logic [15:0] sout;
    logic [1:0]  ratio;

    int n_chk = 0;
    int n_fail = 0;

    audio_ratio_detector u_audio_ratio_detector (
        .clk          (clk),
        .rst_n        (rst_n),
        .wclk_in      (wclk),
        .sample_in    (sin),
        .sample_valid (valid),
        .sample_out   (sout),
        .resync       (resync),
        .locked       (locked),
        .ratio        (ratio)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        int p;    // period that starts with this row's edge
        int s;    // sample presented at this row's edge
        int v;    // expected sample_valid pulses in the row
        int r;    // expected resync pulses in the row
        int o;    // expected sample_out at end of row
        int lk;   // expected locked
        int rt;   // expected ratio code
        int req;  // requirement tag number for the message
    } row_t;

    // Each row's edge measures the previous row's period.
    localparam row_t TBL [24] = '{
        '{256,  1, 0, 0,  0, 0, 0, 5},  // first edge, no measurement
        '{252,  2, 0, 0,  0, 0, 0, 5},  // measures 256
        '{260,  3, 0, 0,  0, 0, 0, 5},  // measures 252 (boundary)
        '{256,  4, 0, 0,  0, 0, 0, 5},  // measures 260 (boundary)
        '{256,  5, 0, 0,  0, 1, 1, 2},  // R2 fourth match: lock, no sample
        '{260,  6, 1, 0,  6, 1, 1, 6},  // R6 normal
        '{240,  7, 1, 0,  7, 1, 1, 6},  // measures 260, +4
        '{230,  8, 1, 0,  8, 1, 1, 6},  // measures 240, -16 tolerated
        '{256,  9, 0, 1,  8, 1, 1, 7},  // R7 measures 230: drop
        '{290, 10, 1, 0, 10, 1, 1, 6},
        '{256, 11, 1, 1, 10, 1, 1, 8},  // R8 measures 290: repeat
        '{384, 12, 1, 0, 12, 1, 1, 6},
        '{384, 13, 1, 1, 12, 1, 1, 9},  // R9 other ratio 1 of 4, repeat
        '{384, 14, 1, 1, 12, 1, 1, 9},  // 2 of 4
        '{256, 15, 1, 1, 12, 1, 1, 9},  // 3 of 4
        '{384, 16, 1, 0, 16, 1, 1, 9},  // measures 256: run restarts
        '{384, 17, 1, 1, 16, 1, 1, 9},  // 1 of 4
        '{384, 18, 1, 1, 16, 1, 1, 9},  // 2 of 4
        '{384, 19, 1, 1, 16, 1, 1, 9},  // 3 of 4
        '{384, 20, 1, 0, 20, 1, 2, 9},  // R9 4 of 4: switch, normal sample
        '{300, 21, 1, 0, 21, 1, 2, 6},
        '{384, 22, 0, 1, 21, 1, 2, 7},  // measures 300 at 384: drop
        '{384, 23, 1, 0, 23, 1, 2, 6},
        '{388, 24, 1, 0, 24, 1, 2, 6}
    };

    task automatic chk(input bit ok, input string req, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // Drive one word clock period of p master clocks starting with a rising edge.
    task automatic run_period(input int p, input logic [15:0] s,
                              output int nv, output int nr, output logic [15:0] last);
        nv = 0;
        nr = 0;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            if (i > 0) begin
                if (valid)  nv++;
                if (resync) nr++;
            end
            if (i == 0) begin
                wclk = 1'b1;
                sin  = s;
            end
            if (i == p / 2) wclk = 1'b0;
        end
        last = sout;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wclk  = 1'b0;
        sin   = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, act=timeout exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int nv, nr, tv;
        logic [15:0] last;

        // R1: state held in reset
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(!locked && !valid && !resync && ratio == 2'd0 && sout == 16'd0, "R1",
            $sformatf("reset act lk=%0d v=%0d rs=%0d rt=%0d o=%0d exp 0 0 0 0 0",
                      locked, valid, resync, ratio, sout));
        rst_n = 1'b1;

        // Table walk: lock, tolerance, drop, repeat, ratio change.
        foreach (TBL[k]) begin
            run_period(TBL[k].p, 16'(TBL[k].s), nv, nr, last);
            chk(nv == TBL[k].v && nr == TBL[k].r && int'(last) == TBL[k].o &&
                int'(locked) == TBL[k].lk && int'(ratio) == TBL[k].rt,
                $sformatf("R%0d", TBL[k].req),
                $sformatf("row %0d act v=%0d r=%0d o=%0d lk=%0d rt=%0d exp v=%0d r=%0d o=%0d lk=%0d rt=%0d",
                          k, nv, nr, last, locked, ratio,
                          TBL[k].v, TBL[k].r, TBL[k].o, TBL[k].lk, TBL[k].rt));
        end

        // R1: reset while running clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!locked && !valid && !resync && ratio == 2'd0 && sout == 16'd0, "R1",
            $sformatf("mid-run reset act lk=%0d rt=%0d o=%0d exp 0 0 0", locked, ratio, sout));
        do_reset();

        // R4, R5: out-of-window periods never lock, nothing delivered
        tv = 0;
        for (int k = 0; k < 6; k++) begin
            run_period(300, 16'(100 + k), nv, nr, last);
            tv += nv + nr;
        end
        chk(!locked && ratio == 2'd0 && tv == 0, "R4",
            $sformatf("period 300 act lk=%0d rt=%0d pulses=%0d exp 0 0 0", locked, ratio, tv));

        // R4: one bad period restarts the run of matches
        do_reset();
        for (int k = 0; k < 8; k++) begin
            run_period((k == 3) ? 300 : 256, 16'(200 + k), nv, nr, last);
        end
        chk(!locked && ratio == 2'd0, "R4",
            $sformatf("interrupted run act lk=%0d rt=%0d exp 0 0", locked, ratio));
        run_period(256, 16'd300, nv, nr, last);
        chk(locked && ratio == 2'd1 && nv == 0, "R2",
            $sformatf("lock after restart act lk=%0d rt=%0d v=%0d exp 1 1 0", locked, ratio, nv));

        // R3: lock at 384 with boundary periods 388 and 380
        do_reset();
        run_period(384, 16'd1, nv, nr, last);
        run_period(388, 16'd2, nv, nr, last);
        run_period(380, 16'd3, nv, nr, last);
        run_period(384, 16'd4, nv, nr, last);
        run_period(384, 16'd5, nv, nr, last);
        chk(locked && ratio == 2'd2 && nv == 0 && nr == 0, "R3",
            $sformatf("lock 384 act lk=%0d rt=%0d v=%0d r=%0d exp 1 2 0 0", locked, ratio, nv, nr));
        run_period(384, 16'h0055, nv, nr, last);
        chk(nv == 1 && nr == 0 && last == 16'h0055, "R6",
            $sformatf("first sample at 384 act v=%0d r=%0d o=%0h exp 1 0 55", nv, nr, last));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule